// File: doc/BRIEF.md
# Pulse-Swallow Divider Controller

This block sits behind an external dual-modulus prescaler and, with it, forms a programmable frequency divider. It runs on the prescaler's output clock, so every clock edge marks one prescaler cycle. A main counter sets the frame length to N prescaler cycles. A swallow counter holds the modulus-control line high for the first A cycles of the frame, which requests division by P+1, and low for the remaining N-A cycles, which requests division by P. Each frame therefore spans P*N + A prescaler input cycles. On the last cycle of each frame the block emits a one-cycle comparison pulse.

The frame length, the swallow count and the prescaler select bit are sampled only at frame boundaries, so no frame is ever cut short. A frame-length value below 3 is refused. The block raises a flag and the next frame repeats the last accepted length. A swallow count larger than the frame length is clipped to that length. The latched select bit is driven out to the prescaler. A value of 1 picks the lower ratio pair, 64/65, and a value of 0 picks 128/129.

Top module: `swallow_div`

## Requirements
- R1: While reset is high, and until the first frame ends, the block runs its default frame: length DEF_N (default 4) and swallow count DEF_A (default 0). During reset modCtl and compPulse are low and ratioSelOut is 1.
- R2: compPulse is high for exactly one cycle per frame, on cycle N-1 when the cycles of a frame are counted from 0, where N is the frame length in force.
- R3: modCtl is high on frame cycles 0 through A-1 and low on cycles A through N-1, where A is the swallow count in force.
- R4: When cfgA is greater than the accepted frame length, the swallow count in force equals that length, so modCtl stays high for the whole frame.
- R5: cfgErr is high exactly when cfgN is 0, 1 or 2. A frame that begins while cfgN is in that range reuses the previous frame's length and clips cfgA to that length.
- R6: cfgN, cfgA and presSel are sampled only on the clock edge that ends a frame, which is the edge during whose cycle compPulse is high. Changes at any other time do not affect the current frame.
- R7: ratioSelOut equals the presSel value sampled at the start of the current frame.
- R8: The sum over one frame of (P+1 on modCtl-high cycles, P otherwise) equals P*N + A. P is 64 when ratioSelOut is 1 and 128 when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock; one edge per prescaler cycle |
| rst | input | 1 | Asynchronous reset, active high |
| cfgN | input | NW (11) | Requested frame length, legal values 3..2047 |
| cfgA | input | AW (7) | Requested swallow count, 0..127 |
| presSel | input | 1 | Requested prescaler pair: 1 selects 64/65, 0 selects 128/129 |
| modCtl | output | 1 | Modulus control: 1 requests P+1, 0 requests P |
| compPulse | output | 1 | One-cycle pulse on the last cycle of each frame |
| cfgErr | output | 1 | High while cfgN is below 3 |
| ratioSelOut | output | 1 | Prescaler pair select in force for the current frame |

## Verification
Frame lengths 3 through 10 are swept against swallow counts 0 through 12. The sweep covers A of zero, A below N, A equal to N and A above N, so counting, switching and clipping are each tested and can be told apart. The select bit alternates across the sweep, and the per-frame prescaler sum shows that P and the P+1 cycles add up to P*N + A. Illegal lengths 0, 1 and 2 are applied after a known legal length to show that the old length is kept. A change applied mid-frame shows that inputs are sampled only at the boundary. One frame of 2047 with 127 exercises the widest counts.

// File: rtl/swallow_pkg.sv
package swallow_pkg;
  localparam int MIN_N = 3;

  typedef struct packed {
    logic frameEnd;   // last cycle of the current frame
    logic swallowOn;  // P+1 requested this cycle
  } ctlStrb_t;
endpackage

// File: rtl/swallow_dp.sv
module swallow_dp
  import swallow_pkg::*;
#(
  parameter int NW    = 11,
  parameter int AW    = 7,
  parameter int DEF_N = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NW-1:0] cfgN,
  input  logic [AW-1:0] cfgA,
  input  logic          presSel,
  input  ctlStrb_t      strb,
  output logic [NW-1:0] loadN,
  output logic [AW-1:0] loadA,
  output logic          cfgErr,
  output logic          ratioSelOut
);
  logic [NW-1:0] heldN;
  logic [NW-1:0] aWide;
  logic          nLegal;

  assign nLegal = (cfgN >= NW'(MIN_N));
  assign cfgErr = !nLegal;
  assign loadN  = nLegal ? cfgN : heldN;
  assign aWide  = NW'(cfgA);
  // clip swallow count to the frame length it will run with
  assign loadA  = (aWide > loadN) ? loadN[AW-1:0] : cfgA;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      heldN       <= NW'(DEF_N);
      ratioSelOut <= 1'b1;
    end else if (strb.frameEnd) begin
      heldN       <= loadN;
      ratioSelOut <= presSel;
    end
  end
endmodule

// File: rtl/swallow_ctrl.sv
module swallow_ctrl
  import swallow_pkg::*;
#(
  parameter int NW    = 11,
  parameter int AW    = 7,
  parameter int DEF_N = 4,
  parameter int DEF_A = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NW-1:0] loadN,
  input  logic [AW-1:0] loadA,
  output ctlStrb_t      strb
);
  logic [NW-1:0] mainCnt;  // cycles left in frame, minus one
  logic [AW-1:0] swCnt;    // P+1 cycles still to request

  assign strb.frameEnd  = (mainCnt == '0);
  assign strb.swallowOn = (swCnt != '0);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      mainCnt <= NW'(DEF_N - 1);
      swCnt   <= AW'(DEF_A);
    end else if (strb.frameEnd) begin
      mainCnt <= loadN - NW'(1);
      swCnt   <= loadA;
    end else begin
      mainCnt <= mainCnt - NW'(1);
      if (strb.swallowOn) swCnt <= swCnt - AW'(1);
    end
  end
endmodule

// File: rtl/swallow_div.sv
module swallow_div
  import swallow_pkg::*;
#(
  parameter int NW    = 11,
  parameter int AW    = 7,
  parameter int DEF_N = 4,
  parameter int DEF_A = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NW-1:0] cfgN,
  input  logic [AW-1:0] cfgA,
  input  logic          presSel,
  output logic          modCtl,
  output logic          compPulse,
  output logic          cfgErr,
  output logic          ratioSelOut
);
  ctlStrb_t      strb;
  logic [NW-1:0] loadN;
  logic [AW-1:0] loadA;

  swallow_dp #(.NW(NW), .AW(AW), .DEF_N(DEF_N)) u_dp (
    .clk(clk), .rst(rst), .cfgN(cfgN), .cfgA(cfgA), .presSel(presSel),
    .strb(strb), .loadN(loadN), .loadA(loadA), .cfgErr(cfgErr),
    .ratioSelOut(ratioSelOut)
  );

  swallow_ctrl #(.NW(NW), .AW(AW), .DEF_N(DEF_N), .DEF_A(DEF_A)) u_ctrl (
    .clk(clk), .rst(rst), .loadN(loadN), .loadA(loadA), .strb(strb)
  );

  assign modCtl    = strb.swallowOn;
  assign compPulse = strb.frameEnd;
endmodule

// File: rtl/swallow_div_chk.sv
module swallow_div_chk #(
  parameter int NW = 11,
  parameter int AW = 7
) (
  input logic          clk,
  input logic          rst,
  input logic [NW-1:0] cfgN,
  input logic [AW-1:0] cfgA,
  input logic          modCtl,
  input logic          compPulse,
  input logic          ratioSelOut
);
  // R2: frames are at least 3 long, so a pulse is never followed by another
  p_pulse_single_r2: assert property (@(posedge clk) disable iff (rst)
    compPulse |=> !compPulse);

  // R3: a legal frame with zero swallow starts with P
  p_zero_swallow_r3: assert property (@(posedge clk) disable iff (rst)
    (compPulse && cfgN >= NW'(3) && cfgA == '0) |=> !modCtl);

  // R3: a legal frame with nonzero swallow starts with P+1
  p_swallow_start_r3: assert property (@(posedge clk) disable iff (rst)
    (compPulse && cfgN >= NW'(3) && cfgA != '0) |=> modCtl);

  // R6: modulus control can only turn on at a frame boundary
  p_rise_at_boundary_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(modCtl) |-> $past(compPulse));

  // R7: prescaler select changes only at a frame boundary
  p_sel_boundary_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(ratioSelOut) |-> $past(compPulse));
endmodule

bind swallow_div swallow_div_chk #(.NW(NW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .cfgN(cfgN), .cfgA(cfgA), .modCtl(modCtl),
  .compPulse(compPulse), .ratioSelOut(ratioSelOut)
);

// File: tb/tb_swallow_div.sv
module tb_swallow_div;
  localparam int NW = 11;
  localparam int AW = 7;
  localparam int DEF_N = 4;
  localparam int DEF_A = 0;

  logic clk = 1'b0;
  logic rst;
  logic [NW-1:0] cfgN;
  logic [AW-1:0] cfgA;
  logic presSel;
  logic modCtl, compPulse, cfgErr, ratioSelOut;

  int total = 0;
  int bad = 0;
  int k, expN, expA, expSel, sum;
  bit wrapped;
  bit finished = 0;

  swallow_div #(.NW(NW), .AW(AW), .DEF_N(DEF_N), .DEF_A(DEF_A)) dut (
    .clk(clk), .rst(rst), .cfgN(cfgN), .cfgA(cfgA), .presSel(presSel),
    .modCtl(modCtl), .compPulse(compPulse), .cfgErr(cfgErr),
    .ratioSelOut(ratioSelOut)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Check the current cycle, advance the model across the next edge, wait for it.
  task automatic cycle();
    int p, nn;
    #1;
    check(modCtl == (k < expA), "R3/R4 modCtl", modCtl, int'(k < expA));
    check(compPulse == (k == expN - 1), "R2 compPulse", compPulse, int'(k == expN - 1));
    check(ratioSelOut == expSel[0], "R7 ratioSelOut", ratioSelOut, expSel);
    check(cfgErr == (cfgN < 3), "R5 cfgErr", cfgErr, int'(cfgN < 3));
    p = ratioSelOut ? 64 : 128;
    sum += modCtl ? p + 1 : p;
    wrapped = 0;
    if (k == expN - 1) begin
      check(sum == p * expN + expA, "R8 frame sum", sum, p * expN + expA);
      sum = 0;
      nn = (cfgN >= 3) ? int'(cfgN) : expN;
      expA = (int'(cfgA) > nn) ? nn : int'(cfgA);
      expN = nn;
      expSel = int'(presSel);
      k = 0;
      wrapped = 1;
    end else begin
      k++;
    end
    @(negedge clk);
  endtask

  task automatic runFrames(input int n);
    int got = 0;
    while (got < n) begin
      cycle();
      if (wrapped) got++;
    end
  endtask

  initial begin
    #(20 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    if (!finished) $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1;
    cfgN = 11'd5;
    cfgA = 7'd2;
    presSel = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(modCtl == 1'b0, "R1 reset modCtl", modCtl, 0);
    check(compPulse == 1'b0, "R1 reset compPulse", compPulse, 0);
    check(ratioSelOut == 1'b1, "R1 reset ratioSelOut", ratioSelOut, 1);
    @(negedge clk);
    rst = 1'b0;
    k = 0; expN = DEF_N; expA = DEF_A; expSel = 1; sum = 0;
    // R1: first frame runs with defaults even though cfg says 5/2
    runFrames(2);

    // R2 R3 R4 R7 R8: sweep lengths and swallow counts around N
    for (int n = 3; n <= 10; n++) begin
      for (int a = 0; a <= 12; a++) begin
        cfgN = NW'(n);
        cfgA = AW'(a);
        presSel = (n + a) % 2 == 0;
        runFrames(2);
      end
    end

    // R5: illegal lengths keep the last legal one, cfgA clipped to it
    cfgN = 11'd6; cfgA = 7'd3;
    runFrames(2);
    for (int n = 0; n <= 2; n++) begin
      cfgN = NW'(n);
      cfgA = 7'd9;
      runFrames(2);
    end

    // R6: change mid-frame, must not disturb the running frame
    cfgN = 11'd5; cfgA = 7'd1;
    runFrames(2);
    cycle();
    cfgN = 11'd9; cfgA = 7'd4; presSel = 1'b0;
    runFrames(2);

    // widest counts
    cfgN = 11'd2047; cfgA = 7'd127; presSel = 1'b0;
    runFrames(2);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule